// File: doc/BRIEF.md
# Hotplug Event Status and Eject Register Block

This block holds the general-purpose event status and enable words for a hot-pluggable slot controller. It also holds two slot bitmaps that report the most recent insertion or removal, and an eject port. The status and enable words are 16 bits wide and are reached through four byte-wide ports. Status bits are cleared by writing ones. Enable bytes are written directly. The bitmaps and the eject port sit on a separate 32-bit word bus.

A slot controller reports each insertion or removal with a one-cycle event carrying the slot number. The block then keeps only that slot's bit in the matching bitmap and raises the hotplug status bit. When the hotplug enable bit is set, it gives the system control interrupt (SCI) line a single-cycle pulse. Software reads the bitmaps to find the slot, acknowledges the status bit, and writes an eject mask. The block turns that mask into a one-cycle eject strobe with the number of the lowest selected slot, which drives the removal logic downstream.

Top module: `gpe_hotplug_regs`

## Requirements
- R1: Byte port 0 is the low status byte, port 1 the high status byte, port 2 the low enable byte and port 3 the high enable byte. A read strobe returns the addressed byte on `byte_rdata` one cycle later.
- R2: A byte write to a status port clears exactly the bits written as 1 in that byte. The bits written as 0 and the other status byte keep their values.
- R3: A byte write to an enable port replaces that enable byte and leaves the other enable byte unchanged.
- R4: A hotplug event clears both bitmaps, then sets bit `hp_slot` in the up bitmap when `hp_insert`=1 or in the down bitmap when `hp_insert`=0. The result is visible from the cycle after the event.
- R5: A hotplug event sets status bit 1 (port 0, mask 0x02) in the cycle after the event.
- R6: When enable bit 1 is set in the cycle of an event, `sci` is high for exactly the next cycle. When enable bit 1 is clear, `sci` stays low.
- R7: On the word bus, `word_addr`=0 (byte offset 0) reads and writes the up bitmap and `word_addr`=1 (offset 4) reads and writes the down bitmap. A read returns data on `word_rdata` one cycle after the strobe.
- R8: A nonzero word write to `word_addr`=2 (offset 8, eject) gives a one-cycle `eject_strobe` in the next cycle, with `eject_slot` equal to the index of the lowest set bit of the written value.
- R9: An eject write of zero gives no strobe, and a read of the eject port returns zero.
- R10: When an event coincides with a software clear of status bit 1, the bit ends set. When an event coincides with a software bitmap write, the event's bitmap update wins.
- R11: After reset, all status, enable and bitmap bits are zero, and `sci` and `eject_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr_en | input | 1 | Byte port write strobe |
| byte_rd_en | input | 1 | Byte port read strobe |
| byte_port | input | 2 | Byte port select (0..3) |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Registered byte read data |
| word_wr_en | input | 1 | Word bus write strobe |
| word_rd_en | input | 1 | Word bus read strobe |
| word_addr | input | 2 | Word select: 0 up, 1 down, 2 eject |
| word_wdata | input | 32 | Word write data |
| word_rdata | output | 32 | Registered word read data |
| hp_valid | input | 1 | One-cycle hotplug event |
| hp_insert | input | 1 | 1 = insertion, 0 = removal |
| hp_slot | input | 5 | Slot number of the event |
| sci | output | 1 | Interrupt pulse |
| eject_strobe | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot number to eject |

## Verification
Events are applied at slot 5 and at slot 31 with both insertion and removal. This shows that each event replaces the previous one in the bitmaps rather than accumulating, and that the top slot index is handled. Status clears are tried with an all-zero mask, a mask that misses bit 1, a mask that hits it, and a write to the high byte. These patterns separate per-byte write-one-to-clear from plain overwrite. Eject masks with a single bit, several bits, only the top bit, and zero show lowest-bit selection and the zero case. The bench also drives an event in the same cycle as a status clear, and in the same cycle as a bitmap write, to check the priority.

// File: rtl/gpe_hp_pkg.sv
package gpe_hp_pkg;
  // Default geometry of the hotplug register block
  localparam int unsigned EVT_W_DEF   = 16;  // status / enable word width
  localparam int unsigned SLOTS_DEF   = 32;  // number of hotplug slots
  localparam int unsigned WORD_W_DEF  = 32;  // word bus data width
  localparam int unsigned HP_BIT_DEF  = 1;   // status/enable bit used for hotplug

  // Word bus register selects
  typedef enum logic [1:0] {
    WSEL_UP    = 2'd0,
    WSEL_DOWN  = 2'd1,
    WSEL_EJECT = 2'd2,
    WSEL_NONE  = 2'd3
  } wsel_e;
endpackage

// File: rtl/gpe_lane_regs.sv
// Status (write-one-to-clear) and enable (byte replace) words on byte ports.
module gpe_lane_regs #(
  parameter int unsigned EVT_W  = 16,
  parameter int unsigned HP_BIT = 1,
  localparam int unsigned NLANES = EVT_W / 8,
  localparam int unsigned LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1,
  localparam int unsigned PORT_W = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] port,
  input  logic [7:0]        wdata,
  input  logic              hw_set,
  output logic [7:0]        rdata,
  output logic [EVT_W-1:0]  sts_o,
  output logic [EVT_W-1:0]  en_o
);
  localparam int unsigned HP_LANE = HP_BIT / 8;
  localparam int unsigned HP_POS  = HP_BIT % 8;

  logic [NLANES-1:0][7:0] sts_q;
  logic [NLANES-1:0][7:0] en_q;

  logic              sel_en;
  logic [LANE_W-1:0] sel_lane;

  assign sel_en   = port[PORT_W-1];
  assign sel_lane = port[LANE_W-1:0];

  genvar l;
  generate
    for (l = 0; l < NLANES; l++) begin : g_lane
      logic       hit_sts;
      logic       hit_en;
      logic [7:0] clr_mask;
      logic [7:0] set_mask;

      always_comb begin
        hit_sts  = wr_en && !sel_en && (sel_lane == LANE_W'(l));
        hit_en   = wr_en &&  sel_en && (sel_lane == LANE_W'(l));
        clr_mask = hit_sts ? wdata : 8'h00;
        set_mask = 8'h00;
        if (hw_set && (l == HP_LANE))
          set_mask[HP_POS] = 1'b1;
      end

      // Status: clear the ones written, then the hardware set takes priority
      always_ff @(posedge clk) begin
        if (rst) begin
          sts_q[l] <= 8'h00;
        end else begin
          sts_q[l] <= (sts_q[l] & ~clr_mask) | set_mask;
        end
      end

      // Enable: a byte write replaces this lane only
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q[l] <= 8'h00;
        end else if (hit_en) begin
          en_q[l] <= wdata;
        end
      end
    end
  endgenerate

  // Registered read path, returns the value before any same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
    end else if (rd_en) begin
      rdata <= sel_en ? en_q[sel_lane] : sts_q[sel_lane];
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
endmodule

// File: rtl/hp_slot_maps.sv
// Up and down slot bitmaps: written by hotplug events and by software.
module hp_slot_maps
  import gpe_hp_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_insert,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [SLOTS-1:0]  up_o,
  output logic [SLOTS-1:0]  down_o
);
  logic [SLOTS-1:0] up_q;
  logic [SLOTS-1:0] down_q;
  logic [SLOTS-1:0] ev_onehot;
  logic             wr_up;
  logic             wr_down;

  always_comb begin
    ev_onehot          = '0;
    ev_onehot[ev_slot] = 1'b1;
  end

  assign wr_up   = wr_en && (addr == WSEL_UP);
  assign wr_down = wr_en && (addr == WSEL_DOWN);

  // An event overrides a software write in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      up_q   <= '0;
      down_q <= '0;
    end else if (ev_valid) begin
      up_q   <= ev_insert ? ev_onehot : '0;
      down_q <= ev_insert ? '0 : ev_onehot;
    end else begin
      if (wr_up)
        up_q <= wdata[SLOTS-1:0];
      if (wr_down)
        down_q <= wdata[SLOTS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        WSEL_UP:   rdata <= WORD_W'(up_q);
        WSEL_DOWN: rdata <= WORD_W'(down_q);
        default:   rdata <= '0;
      endcase
    end
  end

  assign up_o   = up_q;
  assign down_o = down_q;
endmodule

// File: rtl/eject_pick.sv
// Turns an eject mask into a strobe with the lowest selected slot number.
module eject_pick #(
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [SLOTS-1:0]  mask,
  output logic              strobe,
  output logic [SLOT_W-1:0] slot
);
  logic [SLOT_W-1:0] low_idx;
  logic              any_set;

  // Scan from the top so the lowest set bit is the last assignment
  always_comb begin
    low_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mask[i])
        low_idx = SLOT_W'(i);
    end
  end

  assign any_set = |mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= 1'b0;
      slot   <= '0;
    end else begin
      strobe <= req && any_set;
      if (req && any_set)
        slot <= low_idx;
    end
  end
endmodule

// File: rtl/gpe_hotplug_regs.sv
module gpe_hotplug_regs
  import gpe_hp_pkg::*;
#(
  parameter int unsigned EVT_W  = EVT_W_DEF,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned HP_BIT = HP_BIT_DEF,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_wr_en,
  input  logic              byte_rd_en,
  input  logic [1:0]        byte_port,
  input  logic [7:0]        byte_wdata,
  output logic [7:0]        byte_rdata,
  input  logic              word_wr_en,
  input  logic              word_rd_en,
  input  logic [1:0]        word_addr,
  input  logic [WORD_W-1:0] word_wdata,
  output logic [WORD_W-1:0] word_rdata,
  input  logic              hp_valid,
  input  logic              hp_insert,
  input  logic [SLOT_W-1:0] hp_slot,
  output logic              sci,
  output logic              eject_strobe,
  output logic [SLOT_W-1:0] eject_slot
);
  logic [EVT_W-1:0] gpe_sts_w;
  logic [EVT_W-1:0] gpe_en_w;
  logic [SLOTS-1:0] up_map_w;
  logic [SLOTS-1:0] down_map_w;
  logic             sci_q;
  logic             eject_req;

  gpe_lane_regs #(
    .EVT_W  (EVT_W),
    .HP_BIT (HP_BIT)
  ) u_lanes (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (byte_wr_en),
    .rd_en  (byte_rd_en),
    .port   (byte_port),
    .wdata  (byte_wdata),
    .hw_set (hp_valid),
    .rdata  (byte_rdata),
    .sts_o  (gpe_sts_w),
    .en_o   (gpe_en_w)
  );

  hp_slot_maps #(
    .SLOTS  (SLOTS),
    .WORD_W (WORD_W)
  ) u_maps (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (hp_valid),
    .ev_insert (hp_insert),
    .ev_slot   (hp_slot),
    .wr_en     (word_wr_en),
    .rd_en     (word_rd_en),
    .addr      (word_addr),
    .wdata     (word_wdata),
    .rdata     (word_rdata),
    .up_o      (up_map_w),
    .down_o    (down_map_w)
  );

  assign eject_req = word_wr_en && (word_addr == WSEL_EJECT);

  eject_pick #(
    .SLOTS (SLOTS)
  ) u_eject (
    .clk    (clk),
    .rst    (rst),
    .req    (eject_req),
    .mask   (word_wdata[SLOTS-1:0]),
    .strobe (eject_strobe),
    .slot   (eject_slot)
  );

  // Interrupt pulse: enable sampled in the event cycle, high for one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      sci_q <= 1'b0;
    end else begin
      sci_q <= hp_valid && gpe_en_w[HP_BIT];
    end
  end

  assign sci = sci_q;
endmodule

// File: rtl/gpe_hotplug_checker.sv
module gpe_hotplug_checker #(
  parameter int unsigned EVT_W  = 16,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HP_BIT = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              hp_valid,
  input logic [EVT_W-1:0]  gpe_en,
  input logic [EVT_W-1:0]  gpe_sts,
  input logic [SLOTS-1:0]  up_map,
  input logic [SLOTS-1:0]  down_map,
  input logic              sci,
  input logic              word_wr_en,
  input logic [1:0]        word_addr,
  input logic [WORD_W-1:0] word_wdata,
  input logic              eject_strobe
);
  // R4: after an event exactly one bit is set across both bitmaps
  p_maps_single_r4: assert property (@(posedge clk) disable iff (rst)
    hp_valid |=> ($countones(up_map) + $countones(down_map)) == 1);

  // R5 and R10: event sets the hotplug status bit regardless of a same-cycle clear
  p_status_set_r5: assert property (@(posedge clk) disable iff (rst)
    hp_valid |=> gpe_sts[HP_BIT]);

  // R6: enabled event yields an interrupt pulse
  p_sci_follows_r6: assert property (@(posedge clk) disable iff (rst)
    hp_valid && gpe_en[HP_BIT] |=> sci);

  // R6: interrupt only after an enabled event
  p_sci_cause_r6: assert property (@(posedge clk) disable iff (rst)
    sci |-> $past(hp_valid && gpe_en[HP_BIT]));

  // R8: eject strobe only after a nonzero eject write
  p_eject_cause_r8: assert property (@(posedge clk) disable iff (rst)
    eject_strobe |-> $past(word_wr_en && word_addr == 2'd2 && word_wdata[SLOTS-1:0] != '0));

  // R9: zero mask gives no strobe
  p_eject_zero_r9: assert property (@(posedge clk) disable iff (rst)
    word_wr_en && word_addr == 2'd2 && word_wdata[SLOTS-1:0] == '0 |=> !eject_strobe);
endmodule

bind gpe_hotplug_regs gpe_hotplug_checker #(
  .EVT_W  (EVT_W),
  .SLOTS  (SLOTS),
  .WORD_W (WORD_W),
  .HP_BIT (HP_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .hp_valid     (hp_valid),
  .gpe_en       (gpe_en_w),
  .gpe_sts      (gpe_sts_w),
  .up_map       (up_map_w),
  .down_map     (down_map_w),
  .sci          (sci),
  .word_wr_en   (word_wr_en),
  .word_addr    (word_addr),
  .word_wdata   (word_wdata),
  .eject_strobe (eject_strobe)
);

// File: tb/gpe_hotplug_regs_tb_top.sv
`timescale 1ns/1ps
module gpe_hotplug_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        byte_wr_en, byte_rd_en;
  logic [1:0]  byte_port;
  logic [7:0]  byte_wdata, byte_rdata;
  logic        word_wr_en, word_rd_en;
  logic [1:0]  word_addr;
  logic [31:0] word_wdata, word_rdata;
  logic        hp_valid, hp_insert;
  logic [4:0]  hp_slot;
  logic        sci, eject_strobe;
  logic [4:0]  eject_slot;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  gpe_hotplug_regs dut_i (
    .clk(clk), .rst(rst),
    .byte_wr_en(byte_wr_en), .byte_rd_en(byte_rd_en), .byte_port(byte_port),
    .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
    .word_wr_en(word_wr_en), .word_rd_en(word_rd_en), .word_addr(word_addr),
    .word_wdata(word_wdata), .word_rdata(word_rdata),
    .hp_valid(hp_valid), .hp_insert(hp_insert), .hp_slot(hp_slot),
    .sci(sci), .eject_strobe(eject_strobe), .eject_slot(eject_slot)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    byte_wr_en = 0; byte_rd_en = 0; byte_port = 0; byte_wdata = 0;
    word_wr_en = 0; word_rd_en = 0; word_addr = 0; word_wdata = 0;
    hp_valid = 0; hp_insert = 0; hp_slot = 0;
  endtask

  task automatic byte_wr(input logic [1:0] p, input logic [7:0] d);
    byte_wr_en = 1; byte_port = p; byte_wdata = d;
    @(negedge clk);
    byte_wr_en = 0;
  endtask

  task automatic byte_rd(input logic [1:0] p, output logic [7:0] d);
    byte_rd_en = 1; byte_port = p;
    @(negedge clk);
    byte_rd_en = 0;
    d = byte_rdata;
  endtask

  task automatic word_wr(input logic [1:0] a, input logic [31:0] d);
    word_wr_en = 1; word_addr = a; word_wdata = d;
    @(negedge clk);
    word_wr_en = 0;
  endtask

  task automatic word_rd(input logic [1:0] a, output logic [31:0] d);
    word_rd_en = 1; word_addr = a;
    @(negedge clk);
    word_rd_en = 0;
    d = word_rdata;
  endtask

  // One-cycle event; returns sci in the cycle after and in the one after that
  task automatic hp_event(input logic ins, input logic [4:0] s, output logic s1, output logic s2);
    hp_valid = 1; hp_insert = ins; hp_slot = s;
    @(negedge clk);
    hp_valid = 0;
    s1 = sci;
    @(negedge clk);
    s2 = sci;
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [31:0] w;
    chk("R11", "sci after reset", 32'(sci), 0);
    chk("R11", "eject_strobe after reset", 32'(eject_strobe), 0);
    for (int p = 0; p < 4; p++) begin
      byte_rd(2'(p), b);
      chk("R11", "byte port after reset", 32'(b), 0);
    end
    word_rd(2'd0, w); chk("R11", "up after reset", w, 0);
    word_rd(2'd1, w); chk("R11", "down after reset", w, 0);
  endtask

  task automatic t_enable_lanes();
    logic [7:0] b;
    byte_wr(2'd3, 8'hA5);
    byte_wr(2'd2, 8'h3C);
    byte_rd(2'd2, b); chk("R1", "enable low byte port 2", 32'(b), 32'h3C);
    byte_rd(2'd3, b); chk("R1", "enable high byte port 3", 32'(b), 32'hA5);
    byte_wr(2'd2, 8'hFF);
    byte_rd(2'd3, b); chk("R3", "high enable kept on low write", 32'(b), 32'hA5);
    byte_rd(2'd2, b); chk("R3", "low enable replaced", 32'(b), 32'hFF);
    byte_rd(2'd0, b); chk("R1", "status low unaffected by enable", 32'(b), 0);
  endtask

  task automatic t_insert_sci();
    logic s1, s2; logic [7:0] b; logic [31:0] w;
    hp_event(1'b1, 5'd5, s1, s2);
    chk("R6", "sci high after enabled event", 32'(s1), 1);
    chk("R6", "sci low one cycle later", 32'(s2), 0);
    word_rd(2'd0, w); chk("R4", "up after insert slot 5", w, 32'h0000_0020);
    word_rd(2'd1, w); chk("R4", "down after insert slot 5", w, 0);
    byte_rd(2'd0, b); chk("R5", "status bit1 set", 32'(b), 32'h02);
    byte_rd(2'd1, b); chk("R1", "status high byte", 32'(b), 0);
  endtask

  task automatic t_remove_nosci();
    logic s1, s2; logic [31:0] w;
    byte_wr(2'd2, 8'hFD);  // drop enable bit 1
    hp_event(1'b0, 5'd31, s1, s2);
    chk("R6", "no sci when enable bit1 clear", 32'(s1), 0);
    chk("R6", "no sci second cycle", 32'(s2), 0);
    word_rd(2'd0, w); chk("R4", "up cleared by remove event", w, 0);
    word_rd(2'd1, w); chk("R4", "down after remove slot 31", w, 32'h8000_0000);
  endtask

  task automatic t_status_clear();
    logic [7:0] b;
    byte_wr(2'd0, 8'h00);
    byte_rd(2'd0, b); chk("R2", "zero mask keeps status", 32'(b), 32'h02);
    byte_wr(2'd0, 8'hFD);
    byte_rd(2'd0, b); chk("R2", "mask missing bit1 keeps status", 32'(b), 32'h02);
    byte_wr(2'd1, 8'hFF);
    byte_rd(2'd0, b); chk("R2", "high byte clear keeps low byte", 32'(b), 32'h02);
    byte_wr(2'd0, 8'h02);
    byte_rd(2'd0, b); chk("R2", "bit1 cleared by one", 32'(b), 0);
  endtask

  task automatic t_collision();
    logic [7:0] b; logic [31:0] w;
    // event and status clear in the same cycle
    hp_valid = 1; hp_insert = 1; hp_slot = 5'd9;
    byte_wr_en = 1; byte_port = 2'd0; byte_wdata = 8'hFF;
    @(negedge clk);
    hp_valid = 0; byte_wr_en = 0;
    byte_rd(2'd0, b); chk("R10", "event beats status clear", 32'(b), 32'h02);
    // event and bitmap write in the same cycle
    hp_valid = 1; hp_insert = 1; hp_slot = 5'd0;
    word_wr_en = 1; word_addr = 2'd0; word_wdata = 32'hFFFF_0000;
    @(negedge clk);
    hp_valid = 0; word_wr_en = 0;
    word_rd(2'd0, w); chk("R10", "event beats bitmap write", w, 32'h0000_0001);
  endtask

  task automatic t_bitmap_sw();
    logic [31:0] w;
    word_wr(2'd0, 32'h1234_5678);
    word_wr(2'd1, 32'h8765_4321);
    word_rd(2'd0, w); chk("R7", "up software write", w, 32'h1234_5678);
    word_rd(2'd1, w); chk("R7", "down software write", w, 32'h8765_4321);
  endtask

  task automatic t_eject(input logic [31:0] mask, input logic exp_stb, input logic [4:0] exp_slot);
    word_wr_en = 1; word_addr = 2'd2; word_wdata = mask;
    @(negedge clk);
    word_wr_en = 0;
    if (exp_stb) begin
      chk("R8", "eject strobe", 32'(eject_strobe), 1);
      chk("R8", "eject slot", 32'(eject_slot), 32'(exp_slot));
    end else begin
      chk("R9", "no strobe for zero mask", 32'(eject_strobe), 0);
    end
    @(negedge clk);
    chk("R8", "strobe one cycle only", 32'(eject_strobe), 0);
  endtask

  task automatic t_eject_read();
    logic [31:0] w;
    word_rd(2'd2, w); chk("R9", "eject port reads zero", w, 0);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_enable_lanes();
    t_insert_sci();
    t_remove_nosci();
    t_status_clear();
    t_collision();
    t_bitmap_sw();
    t_eject(32'h0000_0020, 1'b1, 5'd5);
    t_eject(32'h0000_0128, 1'b1, 5'd3);
    t_eject(32'h8000_0000, 1'b1, 5'd31);
    t_eject(32'h0000_0000, 1'b0, 5'd0);
    t_eject_read();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule